// File: doc/BRIEF.md
# Skewed-Feed Systolic Matrix Multiplier

This block multiplies two small square matrices of signed integers on a grid of processing elements. Each element keeps its own running sum, so the results stay where they are computed. Operands travel through the grid: values from the left matrix move one element to the right on each clock, and values from the right matrix move one element down. A cycle-counted sequencer starts when reset is released. It pushes row `i` of the left matrix into grid row `i`, and column `j` of the right matrix into grid column `j`. Row `i` and column `j` are delayed by `i` and `j` cycles, so each pair of operands meets at the element that owns their product. When the sequence ends, a global accumulate enable drops. A sticky completion flag then rises on the same edge that the last registered result becomes valid.

To run a new multiplication, apply new matrices and pulse reset. Both matrices must stay stable from the release of reset until completion. With the default size (`N = 2`, 8-bit operands, 16-bit sums), the final results appear on the 7th rising edge after reset is released. In general this is edge `3N+1`.

Top module: `sa_array`

## Requirements
- R1: Each element copies its incoming left-matrix operand to its right neighbour and its incoming right-matrix operand to its lower neighbour through a register on every clock, whether or not the enable is high.
- R2: When the enable is high and at least one incoming operand is nonzero, an element adds the signed product of its two operands to its running sum, wrapping modulo 2^AW. -128 times -128, summed twice, gives 16'h8000.
- R3: An element's running sum holds when the enable is low or when both incoming operands are zero. Once the sequence ends, the outputs stay unchanged for as long as reset stays low.
- R4: Each result output is a register that copies the running sum one cycle later. For N=2, element (0,0) shows A[0][0]*B[0][0] after edge 4 and its full dot product after edge 5.
- R5: A step counter starts at zero out of reset, advances once per clock and stops at 3N-1 (5 for N=2). The enable is a register that is high only while the counter is below that value, so accumulation stops after edge 3N.
- R6: Row i of the left matrix enters grid row i, and column j of the right matrix enters grid column j. Element k of each enters when the counter equals k+1+i (or k+1+j). At all other times the feed registers hold zero.
- R7: For N=2, after edge 7 output C[i][j] equals A[i][0]*B[0][j] + A[i][1]*B[1][j] modulo 2^16. Element (i,k) of A is at a_mat bits [(i*N+k)*DW +: DW], B uses the same layout, and C[i][j] is at c_mat bits [(i*N+j)*AW +: AW].
- R8: done is low through edge 3N. It rises on edge 3N+1 (edge 7 for N=2) and stays high until the next reset.
- R9: A synchronous active-high reset clears every forwarded operand, running sum, result register, feed register, the counter, the enable and done. Releasing reset, including after an aborted run, starts a fresh sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a sequence |
| a_mat | input | N*N*DW | Left matrix, row-major, signed elements |
| b_mat | input | N*N*DW | Right matrix, row-major, signed elements |
| c_mat | output | N*N*AW | Registered product matrix, row-major, signed sums |
| done | output | 1 | Sticky flag: the results in c_mat are final |

## Verification
The bench builds the array at its defaults: N=2, 8-bit operands and 16-bit sums. Because the sum is exactly twice the operand width, two full-scale negative products add up to a value that wraps to 16'h8000, so the modulo behaviour can be observed at the outputs. The small grid also makes every intermediate edge observable. The bench can therefore check the partial sum of element (0,0) at edge 4, the timing of done at edges 6 and 7, and a reset applied in the middle of a run, all against hand-derived edge counts.

// File: rtl/sa_pkg.sv
package sa_pkg;

  // Last value of the feed step counter for an n-by-n grid. The final
  // product reaches element (n-1,n-1) on edge 3n after reset release.
  function automatic int last_step(input int n);
    return 3 * n - 1;
  endfunction

  // Counter width able to hold last_step(n).
  function automatic int step_width(input int n);
    return $clog2(3 * n);
  endfunction

endpackage

// File: rtl/sa_mac.sv
module sa_mac #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic signed [DW-1:0] op_a,
  input  logic signed [DW-1:0] op_b,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_out
);

  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_fit;

  assign prod     = op_a * op_b;
  assign prod_fit = AW'(prod);
  assign sum_out  = sum_in + prod_fit;

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] b_in,
  output logic signed [DW-1:0] a_out,
  output logic signed [DW-1:0] b_out,
  output logic signed [AW-1:0] res_out
);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_nxt;
  logic                 live_ops;

  sa_mac #(.DW(DW), .AW(AW)) u_mac (
    .op_a    (a_in),
    .op_b    (b_in),
    .sum_in  (acc),
    .sum_out (acc_nxt)
  );

  assign live_ops = (a_in != '0) || (b_in != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out   <= '0;
      b_out   <= '0;
      acc     <= '0;
      res_out <= '0;
    end else begin
      a_out   <= a_in;
      b_out   <= b_in;
      res_out <= acc;
      if (en && live_ops) begin
        acc <= acc_nxt;
      end
    end
  end

  logic chk_armed = 1'b0;
  always_ff @(posedge clk) chk_armed <= !rst;

  AST_FWD_A: assert property (@(posedge clk) disable iff (rst) chk_armed |-> a_out == $past(a_in)); // R1
  AST_FWD_B: assert property (@(posedge clk) disable iff (rst) chk_armed |-> b_out == $past(b_in)); // R1
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) chk_armed && $past(!en || (a_in == '0 && b_in == '0)) |-> acc == $past(acc)); // R3
  AST_OUT_LAG: assert property (@(posedge clk) disable iff (rst) chk_armed |-> res_out == $past(acc)); // R4

endmodule

// File: rtl/sa_feeder.sv
module sa_feeder #(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic              en,
  output logic              seq_end,
  output logic [N*DW-1:0]   a_feed,
  output logic [N*DW-1:0]   b_feed
);

  localparam int LAST = sa_pkg::last_step(N);
  localparam int CW   = sa_pkg::step_width(N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      en  <= 1'b0;
    end else begin
      if (cnt != CW'(LAST)) begin
        cnt <= cnt + 1'b1;
      end
      en <= (cnt < CW'(LAST));
    end
  end

  assign seq_end = (cnt == CW'(LAST));

  // Lane g (row g of A, column g of B) is delayed g steps.
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [DW-1:0] a_nxt;
    logic [DW-1:0] b_nxt;

    always_comb begin
      a_nxt = '0;
      b_nxt = '0;
      for (int k = 0; k < N; k++) begin
        if (int'(cnt) == k + 1 + g) begin
          a_nxt = a_mat[(g*N+k)*DW +: DW];
          b_nxt = b_mat[(k*N+g)*DW +: DW];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        a_feed[g*DW +: DW] <= '0;
        b_feed[g*DW +: DW] <= '0;
      end else begin
        a_feed[g*DW +: DW] <= a_nxt;
        b_feed[g*DW +: DW] <= b_nxt;
      end
    end
  end

  logic chk_armed = 1'b0;
  always_ff @(posedge clk) chk_armed <= !rst;

  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(LAST)); // R5
  AST_EN_DROP: assert property (@(posedge clk) disable iff (rst) chk_armed && $fell(en) |-> seq_end); // R5
  AST_FEED_IDLE: assert property (@(posedge clk) disable iff (rst) chk_armed && !en |-> a_feed == '0 && b_feed == '0); // R6

endmodule

// File: rtl/sa_array.sv
module sa_array #(
  parameter int N  = 2,
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic [N*N*AW-1:0] c_mat,
  output logic              done
);

  logic            en;
  logic            seq_end;
  logic [N*DW-1:0] a_feed;
  logic [N*DW-1:0] b_feed;

  sa_feeder #(.N(N), .DW(DW)) u_feed (
    .clk     (clk),
    .rst     (rst),
    .a_mat   (a_mat),
    .b_mat   (b_mat),
    .en      (en),
    .seq_end (seq_end),
    .a_feed  (a_feed),
    .b_feed  (b_feed)
  );

  // a_h[i][j]: operand entering element (i,j) from the left.
  // b_v[i][j]: operand entering element (i,j) from above.
  logic signed [DW-1:0] a_h [N][N+1];
  logic signed [DW-1:0] b_v [N+1][N];
  logic signed [AW-1:0] c_w [N][N];
  logic [2*N*DW-1:0]    unused_edge;

  for (genvar i = 0; i < N; i++) begin : g_row
    assign a_h[0+i][0] = a_feed[i*DW +: DW];
    assign b_v[0][i]   = b_feed[i*DW +: DW];
    assign unused_edge[i*DW +: DW]       = a_h[i][N];
    assign unused_edge[(N+i)*DW +: DW]   = b_v[N][i];

    for (genvar j = 0; j < N; j++) begin : g_col
      sa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .a_in    (a_h[i][j]),
        .b_in    (b_v[i][j]),
        .a_out   (a_h[i][j+1]),
        .b_out   (b_v[i+1][j]),
        .res_out (c_w[i][j])
      );
      assign c_mat[(i*N+j)*AW +: AW] = c_w[i][j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
    end else if (seq_end && !en) begin
      done <= 1'b1;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) done |=> done); // R8
  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (rst) done |-> !en && seq_end); // R8

endmodule

// File: tb/sa_array_bench.sv
`timescale 1ns/1ps
module sa_array_bench;

  localparam int N  = 2;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int FIN = 3 * N + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N*N*DW-1:0] a_m = '0;
  logic [N*N*DW-1:0] b_m = '0;
  logic [N*N*AW-1:0] c_m;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sa_array #(.N(N), .DW(DW), .AW(AW)) u_sa_array (
    .clk   (clk),
    .rst   (rst),
    .a_mat (a_m),
    .b_mat (b_m),
    .c_mat (c_m),
    .done  (done)
  );

  function automatic logic [AW-1:0] ref_c(input logic [N*N*DW-1:0] am,
                                          input logic [N*N*DW-1:0] bm,
                                          input int i, input int j);
    int s;
    s = 0;
    for (int k = 0; k < N; k++) begin
      s += int'($signed(am[(i*N+k)*DW +: DW])) * int'($signed(bm[(k*N+j)*DW +: DW]));
    end
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] get_c(input int i, input int j);
    return c_m[(i*N+j)*AW +: AW];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R9: hold reset for a few cycles, check cleared state, release at a falling edge.
  task automatic do_reset(input string tag);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", {tag, " reset done"}, AW'(done), '0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        check("R9", {tag, " reset c"}, get_c(i, j), '0);
    rst = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [N*N*DW-1:0] am,
                          input logic [N*N*DW-1:0] bm);
    logic [AW-1:0] p00;
    a_m = am;
    b_m = bm;
    p00 = AW'($signed(am[0 +: DW]) * $signed(bm[0 +: DW]));
    do_reset(tag);
    for (int m = 1; m <= FIN; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 4) check("R4", {tag, " partial c00 edge4"}, get_c(0, 0), p00);
      if (m == 5) check("R4", {tag, " c00 edge5"}, get_c(0, 0), ref_c(am, bm, 0, 0));
      if (m == FIN - 1) check("R8", {tag, " done before final"}, AW'(done), '0);
    end
    check("R8", {tag, " done at final edge"}, AW'(done), 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        check("R7", {tag, " final c (R1 R2 R6)"}, get_c(i, j), ref_c(am, bm, i, j));
    repeat (6) @(negedge clk);
    check("R8", {tag, " done sticky"}, AW'(done), 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        check("R3", {tag, " hold after end (R5)"}, get_c(i, j), ref_c(am, bm, i, j));
  endtask

  task automatic abort_case();
    a_m = {8'sd9, 8'sd7, -8'sd5, 8'sd3};
    b_m = {8'sd4, -8'sd6, 8'sd2, 8'sd8};
    do_reset("abort");
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9", "mid-run reset done", AW'(done), '0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        check("R9", "mid-run reset c", get_c(i, j), '0);
    run_case("after-abort", a_m, b_m);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N*N*DW-1:0] ra;
    logic [N*N*DW-1:0] rb;
    // Layout {e11, e10, e01, e00}: element (i,k) at bits (i*N+k)*DW.
    run_case("identity", {8'sd1, 8'sd0, 8'sd0, 8'sd1}, {-8'sd7, 8'sd5, 8'sd3, 8'sd2});
    run_case("extreme",  {8'h80, 8'h80, 8'h80, 8'h80}, {8'h80, 8'h80, 8'h80, 8'h80});
    run_case("zeros",    {8'sd0, 8'sd6, -8'sd3, 8'sd0}, {8'sd0, 8'sd0, 8'sd5, -8'sd4});
    run_case("mixed",    {8'h7f, 8'h80, 8'h80, 8'h7f}, {8'h7f, 8'h7f, 8'h80, 8'h80});
    abort_case();
    for (int t = 0; t < 6; t++) begin
      ra = N*N*DW'($urandom);
      rb = N*N*DW'($urandom);
      run_case("random", ra, rb);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule